// File: doc/BRIEF.md
# Pipelined Indirect Table Lookup Comparator

This block holds two byte-wide tables of 256 entries. A lookup supplies a pointer and a reference byte. The pointer reads the first table, called the index table. The byte found there is captured in a register and then used as the address into the second table, called the data table. The byte read from the data table is compared with the reference byte, and the block reports whether the two are equal.

Both tables are read on a clock edge, and each table has exactly one write port and one read port. A synthesis tool can therefore map each table to a block RAM instead of building it from logic cells. All lookups pass through a single shared pipeline. A new lookup can be accepted on every cycle. Each lookup's result appears after two rising edges, together with the reference byte of that same request.

Each table has its own write port. A read and a write to the same entry on the same edge return the entry's old value.

Top module: `lkp_chain_top`

## Requirements
- R1: While rst_n is low, and on the first edge after rst_n is released with no request pending, res_vld is 0.
- R2: A request sampled with req_vld=1 on a rising edge produces res_vld=1 after exactly the second rising edge that follows it.
- R3: res_match is 1 exactly when DATA[INDEX[req_ptr]] equals req_ref. INDEX and DATA are 8-bit tables addressed 0 to 255.
- R4: Each result is compared against the req_ref of its own request, even when back-to-back requests carry different reference bytes.
- R5: Requests on consecutive cycles each produce a result on consecutive cycles, with no bubbles.
- R6: When iw_en=1, iw_data is stored at iw_addr in the index table. A lookup that reads that entry on the same edge sees the old value.
- R7: When dw_en=1, dw_data is stored at dw_addr in the data table. A data-table read of that entry on the same edge sees the old value.
- R8: A cycle with req_vld=0 yields res_vld=0 two edges later.
- R9: Reset clears only the pipeline valid flags. Table contents survive a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| iw_en | input | 1 | Index table write enable |
| iw_addr | input | 8 | Index table write address |
| iw_data | input | 8 | Index table write data |
| dw_en | input | 1 | Data table write enable |
| dw_addr | input | 8 | Data table write address |
| dw_data | input | 8 | Data table write data |
| req_vld | input | 1 | Lookup request valid |
| req_ptr | input | 8 | Pointer into the index table |
| req_ref | input | 8 | Reference byte to compare against |
| res_vld | output | 1 | Result valid |
| res_match | output | 1 | Data table entry equals the reference byte |

## Verification
The bench targets several corner cases, and each one exposes a specific kind of fault:
- Same-edge write and read on each table. A design that forwarded the new data would report a match against the freshly written byte instead of the old one.
- Back-to-back requests with alternating reference bytes. A reference stage that is misaligned compares against the neighbouring request's byte, so matches and misses swap.
- A reset issued while lookups are in flight. Valid flags left standing would produce stray results.
- A lookup made after that reset. A design that wiped the tables would return misses where the stored entries should still match.
- A counted two-edge latency. An extra or missing register shifts every result by one cycle.

// File: rtl/lkp_pkg.sv
package lkp_pkg;
  localparam int unsigned LKP_ADDR_W = 8;
  localparam int unsigned LKP_DATA_W = 8;
  localparam int unsigned LKP_DEPTH  = 1 << LKP_ADDR_W;
endpackage

// File: rtl/lkp_ram.sv
module lkp_ram #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // write port
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // clocked read port, old contents on a same-edge collision
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

  // R6 R7
  wr_store_chk: assert property (@(posedge clk)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_data));

  // R6 R7
  rbw_chk: assert property (@(posedge clk)
    (rd_en && wr_en && rd_addr == wr_addr) |=> rd_data == $past(mem[rd_addr]));
endmodule

// File: rtl/lkp_cmp.sv
module lkp_cmp #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              vld,
  input  logic [DATA_W-1:0] entry,
  input  logic [DATA_W-1:0] ref_byte,
  output logic              res_vld,
  output logic              res_match
);
  always_comb begin
    res_vld   = vld;
    res_match = vld && (entry == ref_byte);
  end
endmodule

// File: rtl/lkp_chain_top.sv
module lkp_chain_top
  import lkp_pkg::*;
#(
  parameter int unsigned ADDR_W = LKP_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iw_en,
  input  logic [ADDR_W-1:0] iw_addr,
  input  logic [ADDR_W-1:0] iw_data,
  input  logic              dw_en,
  input  logic [ADDR_W-1:0] dw_addr,
  input  logic [ADDR_W-1:0] dw_data,
  input  logic              req_vld,
  input  logic [ADDR_W-1:0] req_ptr,
  input  logic [ADDR_W-1:0] req_ref,
  output logic              res_vld,
  output logic              res_match
);
  // index entries are data-table addresses, so both tables share one width
  localparam int unsigned W = ADDR_W;

  logic         s1_vld, s2_vld;
  logic         s1_vld_nxt, s2_vld_nxt;
  logic [W-1:0] s1_ref, s2_ref;
  logic [W-1:0] idx_q;
  logic [W-1:0] dat_q;

  lkp_ram #(.ADDR_W(W), .DATA_W(W)) u_idx_ram (
    .clk     (clk),
    .wr_en   (iw_en),
    .wr_addr (iw_addr),
    .wr_data (iw_data),
    .rd_en   (req_vld),
    .rd_addr (req_ptr),
    .rd_data (idx_q)
  );

  lkp_ram #(.ADDR_W(W), .DATA_W(W)) u_dat_ram (
    .clk     (clk),
    .wr_en   (dw_en),
    .wr_addr (dw_addr),
    .wr_data (dw_data),
    .rd_en   (s1_vld),
    .rd_addr (idx_q),
    .rd_data (dat_q)
  );

  // valid pipeline next state
  always_comb begin
    s1_vld_nxt = req_vld;
    s2_vld_nxt = s1_vld;
  end

  // valid pipeline registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s2_vld <= 1'b0;
    end else begin
      s1_vld <= s1_vld_nxt;
      s2_vld <= s2_vld_nxt;
    end
  end

  // reference byte follows its request, loaded only when the stage advances
  always_ff @(posedge clk) begin
    if (req_vld) s1_ref <= req_ref;
    if (s1_vld)  s2_ref <= s1_ref;
  end

  lkp_cmp #(.DATA_W(W)) u_cmp (
    .vld       (s2_vld),
    .entry     (dat_q),
    .ref_byte  (s2_ref),
    .res_vld   (res_vld),
    .res_match (res_match)
  );

  // R2
  stage1_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> s1_vld);

  // R2
  stage2_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> res_vld);

  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> !res_vld);

  // R4
  ref_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> s1_ref == $past(req_ref));
endmodule

// File: tb/lkp_chain_top_tb.sv
module lkp_chain_top_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       iw_en, dw_en, req_vld;
  logic [7:0] iw_addr, iw_data, dw_addr, dw_data, req_ptr, req_ref;
  logic       res_vld, res_match;

  int total = 0;
  int bad   = 0;

  logic [7:0] im [256];
  logic [7:0] dm [256];
  logic       p1_v, e2_v, e2_m;
  logic [7:0] p1_i, p1_r;

  always #5 clk = ~clk;

  lkp_chain_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .iw_en(iw_en), .iw_addr(iw_addr), .iw_data(iw_data),
    .dw_en(dw_en), .dw_addr(dw_addr), .dw_data(dw_data),
    .req_vld(req_vld), .req_ptr(req_ptr), .req_ref(req_ref),
    .res_vld(res_vld), .res_match(res_match)
  );

  task automatic chk(input string rq, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", rq, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, model at posedge, check at next negedge
  task automatic step(input string rq, input logic rv, input logic [7:0] rp,
                      input logic [7:0] rr, input logic iwe, input logic [7:0] ia,
                      input logic [7:0] id, input logic dwe, input logic [7:0] da,
                      input logic [7:0] dd);
    req_vld = rv; req_ptr = rp; req_ref = rr;
    iw_en = iwe; iw_addr = ia; iw_data = id;
    dw_en = dwe; dw_addr = da; dw_data = dd;
    @(posedge clk);
    e2_v = p1_v;
    e2_m = p1_v && (dm[p1_i] == p1_r);
    p1_v = rv;
    if (rv) begin p1_i = im[rp]; p1_r = rr; end
    if (iwe) im[ia] = id;
    if (dwe) dm[da] = dd;
    @(negedge clk);
    chk({rq, " vld"}, res_vld, e2_v);
    if (e2_v) chk({rq, " match"}, res_match, e2_m);
  endtask

  task automatic idle(input string rq);
    step(rq, 1'b0, 8'h0, 8'h0, 1'b0, 8'h0, 8'h0, 1'b0, 8'h0, 8'h0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; p1_v = 1'b0; e2_v = 1'b0;
    req_vld = 1'b1; req_ptr = 8'h0; req_ref = 8'h0;
    iw_en = 0; dw_en = 0; iw_addr = 0; iw_data = 0; dw_addr = 0; dw_data = 0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", res_vld, 1'b0);
    req_vld = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1 after release");
  endtask

  task automatic t_fill();
    for (int k = 0; k < 256; k++)
      step("R6 fill", 1'b0, 0, 0, 1'b1, k[7:0], 8'(255 - k), 1'b1, k[7:0], 8'(k * 3));
    idle("R8 idle"); idle("R8 idle");
  endtask

  task automatic t_basic();
    // INDEX[5]=250, DATA[250]=750 mod 256 = 0xEE
    step("R3 hit", 1'b1, 8'd5, 8'hEE, 0, 0, 0, 0, 0, 0);
    step("R2 lat", 1'b1, 8'd5, 8'hEF, 0, 0, 0, 0, 0, 0);
    step("R3 hit", 1'b0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R3 miss", 1'b0, 0, 0, 0, 0, 0, 0, 0, 0);
    idle("R8 idle");
  endtask

  task automatic t_b2b();
    for (int k = 0; k < 20; k++) begin
      logic [7:0] p;
      p = 8'(k * 7);
      step("R4/R5 b2b", 1'b1, p, (k % 2 == 0) ? dm[im[p]] : ~dm[im[p]],
           0, 0, 0, 0, 0, 0);
    end
    idle("R5 drain"); idle("R5 drain"); idle("R8 idle");
  endtask

  task automatic t_raw_idx();
    // lookup of entry 9 while rewriting it: old index used
    step("R6 rbw", 1'b1, 8'd9, dm[im[9]], 1'b1, 8'd9, 8'd77, 0, 0, 0);
    step("R6 rbw", 1'b1, 8'd9, dm[8'd77], 0, 0, 0, 0, 0, 0);
    idle("R6 rbw"); idle("R6 rbw");
  endtask

  task automatic t_raw_dat();
    logic [7:0] a;
    a = im[8'd20];
    step("R7 rbw", 1'b1, 8'd20, dm[a], 0, 0, 0, 0, 0, 0);
    // data read of a happens now while a is rewritten
    step("R7 rbw", 1'b0, 0, 0, 0, 0, 0, 1'b1, a, ~dm[a]);
    idle("R7 rbw");
    step("R7 new", 1'b1, 8'd20, dm[a], 0, 0, 0, 0, 0, 0);
    idle("R7 new"); idle("R7 new");
  endtask

  task automatic t_midreset();
    step("R9 pre", 1'b1, 8'd30, 8'h00, 0, 0, 0, 0, 0, 0);
    step("R9 pre", 1'b1, 8'd31, 8'h00, 0, 0, 0, 0, 0, 0);
    req_vld = 1'b0;
    rst_n = 1'b0; #1;
    chk("R1 async clear", res_vld, 1'b0);
    p1_v = 1'b0; e2_v = 1'b0;
    @(negedge clk);
    chk("R1 held", res_vld, 1'b0);
    rst_n = 1'b1;
    idle("R1 release");
    step("R9 kept", 1'b1, 8'd30, dm[im[30]], 0, 0, 0, 0, 0, 0);
    idle("R9 kept"); idle("R9 kept");
  endtask

  task automatic t_random();
    for (int k = 0; k < 400; k++) begin
      logic [7:0] p;
      p = 8'($urandom);
      step("R3 rand", 1'($urandom), p, ($urandom % 2) ? dm[im[p]] : 8'($urandom),
           1'($urandom), 8'($urandom), 8'($urandom),
           1'($urandom), 8'($urandom), 8'($urandom));
    end
    idle("R3 drain"); idle("R3 drain");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_fill();
        t_basic();
        t_b2b();
        t_raw_idx();
        t_raw_dat();
        t_midreset();
        t_random();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule